// File: doc/BRIEF.md
# Serial Controller Control-Word Sequencer

A serial controller exposes a single control address, and every setup byte the CPU writes lands there. This block tracks where each write belongs. The first write after a hardware reset configures the line. If that configuration selects synchronous operation, one or two sync-character writes come next. Every write after that is a command. A command can also send the sequence back to the start, so the next byte is read as a fresh configuration.

The configuration fields stay latched until the next configuration write. Each command write replaces the command levels. From a command, the block drives modem-control pins, which are active low, and the transmit, receive, break and hunt enables. It also gives a single-cycle strobe that clears the receiver error flags. All outputs are registered and take their new value on the clock edge that captures the write.

Top module: `ctrl_word_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, the block waits for a configuration word. `rts_n` and `dtr_n` are 1. `tx_en`, `rx_en`, `send_brk`, `hunt` and `err_clr` are 0. All configuration fields and sync registers are 0, so `sync_mode` reads 1.
- R2: A configuration write sets these fields: `stop_sel` from bits 7:6, `par_even` from bit 5, `par_en` from bit 4, `char_len` from bits 3:2 and `clk_fac` from bits 1:0. The fields are visible from the edge that captures the write. They hold their value through every other kind of write.
- R3: A configuration write with a nonzero `clk_fac` makes the next write a command.
- R4: A configuration write with `clk_fac` = 00 raises `sync_mode`. Bit 7 then sets how many sync writes follow: one when set, two when clear. The first sync write goes to `sync_chars[7:0]` and the second to `sync_chars[15:8]`. The write after the last sync write is a command, and sync writes leave the command outputs unchanged.
- R5: A command with bit 6 set returns all command outputs to their R1 values and gives no `err_clr` pulse. The configuration fields are kept, and the next write is again a configuration word.
- R6: A command without bit 6 sets `rts_n` to the inverse of bit 5 and `dtr_n` to the inverse of bit 1. Both hold until the next command.
- R7: A command with bit 4 set and bit 6 clear raises `err_clr` for exactly one cycle.
- R8: A command without bit 6 loads four levels: `tx_en` from bit 0, `rx_en` from bit 2, `send_brk` from bit 3 and `hunt` from bit 7.
- R9: Writing 00, 00, 00 and then 40h leaves the block waiting for a configuration word, whatever its starting state. This holds when the first zeros are taken as a configuration word and sync characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| wr_stb | input | 1 | Control-address write strobe, one cycle per byte |
| wr_data | input | 8 | Byte written to the control address |
| stop_sel | output | 2 | Stop-bit selection field |
| par_even | output | 1 | Even (1) or odd (0) parity |
| par_en | output | 1 | Parity enable |
| char_len | output | 2 | Character length code |
| clk_fac | output | 2 | Clock factor; 00 means synchronous |
| sync_mode | output | 1 | High when `clk_fac` is 00 |
| sync_chars | output | 16 | Sync characters, first in the low byte |
| tx_en | output | 1 | Transmit enable level |
| rx_en | output | 1 | Receive enable level |
| send_brk | output | 1 | Force-break level |
| hunt | output | 1 | Hunt level |
| err_clr | output | 1 | One-cycle strobe clearing the parity, overrun and framing flags |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |

## Verification
Two functions can fall on the same write. The internal reset in bit 6 can arrive in one command byte with request-to-send, data-terminal-ready and error-clear requests. The bench writes 72h so that all four collide on one edge. It then expects idle modem pins and no `err_clr` strobe in the following cycle, and expects the next byte to be decoded as a configuration word. The bench also checks the sequence positions from the outside. It writes a byte and observes which output group changes, and it starts the recovery sequence from each of the four possible write positions.

// File: rtl/csq_pkg.sv
package csq_pkg;
    localparam int DW       = 8;
    localparam int NUM_SYNC = 2;
    localparam int SIDX_W   = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1;

    // command bit positions (decoded by the behaviour)
    localparam int CB_TX   = 0;
    localparam int CB_DTR  = 1;
    localparam int CB_RX   = 2;
    localparam int CB_BRK  = 3;
    localparam int CB_CLR  = 4;
    localparam int CB_RTS  = 5;
    localparam int CB_IRST = 6;
    localparam int CB_HUNT = 7;
    localparam int MB_ONE_SYNC = 7;

    typedef enum logic [1:0] {
        ST_MODE = 2'd0,
        ST_SYNC = 2'd1,
        ST_CMD  = 2'd2
    } wst_e;

    typedef struct packed {
        wst_e              st;
        logic [SIDX_W-1:0] idx;
        logic [SIDX_W-1:0] last;
    } fsm_s;

    typedef struct packed {
        logic [1:0] stop;
        logic       even;
        logic       pen;
        logic [1:0] len;
        logic [1:0] fac;
    } mode_s;

    typedef struct packed {
        logic hunt;
        logic rts;
        logic brk;
        logic rx;
        logic dtr;
        logic tx;
        logic clr;
    } cmd_s;
endpackage

// File: rtl/csq_fsm.sv
module csq_fsm
    import csq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [DW-1:0]       wr_data,
    output logic                mode_we,
    output logic [NUM_SYNC-1:0] sync_we,
    output logic                cmd_we
);
    fsm_s cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        mode_we = 1'b0;
        sync_we = '0;
        cmd_we  = 1'b0;
        if (wr_stb) begin
            unique case (cur_q.st)
                ST_MODE: begin
                    mode_we = 1'b1;
                    if (wr_data[1:0] == 2'b00) begin
                        nxt_d.st   = ST_SYNC;
                        nxt_d.idx  = '0;
                        nxt_d.last = wr_data[MB_ONE_SYNC] ? '0
                                                          : SIDX_W'(NUM_SYNC - 1);
                    end else begin
                        nxt_d.st = ST_CMD;
                    end
                end
                ST_SYNC: begin
                    sync_we[cur_q.idx] = 1'b1;
                    if (cur_q.idx == cur_q.last) nxt_d.st  = ST_CMD;
                    else                         nxt_d.idx = cur_q.idx + 1'b1;
                end
                ST_CMD: begin
                    cmd_we = 1'b1;
                    if (wr_data[CB_IRST]) nxt_d.st = ST_MODE;
                end
                default: nxt_d.st = ST_MODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '{st: ST_MODE, idx: '0, last: '0};
        else     cur_q <= nxt_d;
    end

    // R3
    async_to_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && cur_q.st == ST_MODE && wr_data[1:0] != 2'b00) |=> cur_q.st == ST_CMD);
    // R4
    sync_done_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && cur_q.st == ST_SYNC && cur_q.idx == cur_q.last) |=> cur_q.st == ST_CMD);
    // R5
    irst_to_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && wr_data[CB_IRST]) |=> cur_q.st == ST_MODE);
    // R4
    one_hot_we_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({mode_we, cmd_we, sync_we}) <= 1);
endmodule

// File: rtl/csq_mode_reg.sv
module csq_mode_reg
    import csq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mode_we,
    input  logic [NUM_SYNC-1:0]          sync_we,
    input  logic [DW-1:0]                wr_data,
    output mode_s                        mode_o,
    output logic [NUM_SYNC-1:0][DW-1:0]  sync_o
);
    mode_s mode_q, mode_d;
    logic [NUM_SYNC-1:0][DW-1:0] sync_q, sync_d;

    always_comb begin
        mode_d = mode_q;
        if (mode_we) mode_d = mode_s'(wr_data);
    end

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
        always_comb begin
            sync_d[g] = sync_q[g];
            if (sync_we[g]) sync_d[g] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= '0;
            else     sync_q[g] <= sync_d[g];
        end

        // R4
        sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !sync_we[g] |=> $stable(sync_q[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    assign mode_o = mode_q;
    assign sync_o = sync_q;

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode_q));
endmodule

// File: rtl/csq_cmd_reg.sv
module csq_cmd_reg
    import csq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_we,
    input  logic [DW-1:0] wr_data,
    output cmd_s          cmd_o
);
    cmd_s cmd_q, cmd_d;

    always_comb begin
        cmd_d     = cmd_q;
        cmd_d.clr = 1'b0;
        if (cmd_we) begin
            if (wr_data[CB_IRST]) begin
                cmd_d = '0;
            end else begin
                cmd_d.hunt = wr_data[CB_HUNT];
                cmd_d.rts  = wr_data[CB_RTS];
                cmd_d.brk  = wr_data[CB_BRK];
                cmd_d.rx   = wr_data[CB_RX];
                cmd_d.dtr  = wr_data[CB_DTR];
                cmd_d.tx   = wr_data[CB_TX];
                cmd_d.clr  = wr_data[CB_CLR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    assign cmd_o = cmd_q;

    // R7
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && wr_data[CB_CLR] && !wr_data[CB_IRST]) |=> cmd_q.clr);
    // R7
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> !cmd_q.clr);
    // R5
    irst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && wr_data[CB_IRST]) |=> (!cmd_q.rts && !cmd_q.dtr && !cmd_q.tx && !cmd_q.clr));
    // R6
    modem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> ($stable(cmd_q.rts) && $stable(cmd_q.dtr)));
endmodule

// File: rtl/ctrl_word_seq.sv
module ctrl_word_seq
    import csq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_stb,
    input  logic [DW-1:0]          wr_data,
    output logic [1:0]             stop_sel,
    output logic                   par_even,
    output logic                   par_en,
    output logic [1:0]             char_len,
    output logic [1:0]             clk_fac,
    output logic                   sync_mode,
    output logic [NUM_SYNC*DW-1:0] sync_chars,
    output logic                   tx_en,
    output logic                   rx_en,
    output logic                   send_brk,
    output logic                   hunt,
    output logic                   err_clr,
    output logic                   rts_n,
    output logic                   dtr_n
);
    logic                        mode_we;
    logic                        cmd_we;
    logic [NUM_SYNC-1:0]         sync_we;
    mode_s                       mode_w;
    cmd_s                        cmd_w;
    logic [NUM_SYNC-1:0][DW-1:0] sync_w;

    csq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .mode_we (mode_we),
        .sync_we (sync_we),
        .cmd_we  (cmd_we)
    );

    csq_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .mode_we (mode_we),
        .sync_we (sync_we),
        .wr_data (wr_data),
        .mode_o  (mode_w),
        .sync_o  (sync_w)
    );

    csq_cmd_reg u_cmd (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (cmd_we),
        .wr_data (wr_data),
        .cmd_o   (cmd_w)
    );

    assign stop_sel   = mode_w.stop;
    assign par_even   = mode_w.even;
    assign par_en     = mode_w.pen;
    assign char_len   = mode_w.len;
    assign clk_fac    = mode_w.fac;
    assign sync_mode  = (mode_w.fac == 2'b00);
    assign sync_chars = sync_w;
    assign tx_en      = cmd_w.tx;
    assign rx_en      = cmd_w.rx;
    assign send_brk   = cmd_w.brk;
    assign hunt       = cmd_w.hunt;
    assign err_clr    = cmd_w.clr;
    assign rts_n      = ~cmd_w.rts;
    assign dtr_n      = ~cmd_w.dtr;

    // R6
    rts_level_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !wr_data[CB_IRST]) |=> rts_n == !$past(wr_data[CB_RTS]));
    // R6
    dtr_level_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !wr_data[CB_IRST]) |=> dtr_n == !$past(wr_data[CB_DTR]));
endmodule

// File: tb/sim_ctrl_word_seq.sv
module sim_ctrl_word_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [1:0]  stop_sel, char_len, clk_fac;
    logic        par_even, par_en, sync_mode;
    logic [15:0] sync_chars;
    logic        tx_en, rx_en, send_brk, hunt, err_clr, rts_n, dtr_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ctrl_word_seq u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .stop_sel(stop_sel), .par_even(par_even), .par_en(par_en),
        .char_len(char_len), .clk_fac(clk_fac), .sync_mode(sync_mode),
        .sync_chars(sync_chars), .tx_en(tx_en), .rx_en(rx_en),
        .send_brk(send_brk), .hunt(hunt), .err_clr(err_clr),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_stb  = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // {rts_n,dtr_n,tx_en,rx_en,send_brk,hunt}
    function automatic logic [5:0] cmd_vec();
        return {rts_n, dtr_n, tx_en, rx_en, send_brk, hunt};
    endfunction

    task automatic t_reset();
        hw_reset();
        check("R1 cmd idle", cmd_vec(), 6'b110000);
        check("R1 err_clr", err_clr, 0);
        check("R1 mode fields", {stop_sel, par_even, par_en, char_len, clk_fac}, 0);
        check("R1 sync_mode", sync_mode, 1);
        check("R1 sync regs", sync_chars, 0);
    endtask

    task automatic t_async();
        wr(8'h7A);
        check("R2 mode decode", {stop_sel, par_even, par_en, char_len, clk_fac}, 8'h7A);
        check("R2 sync_mode low", sync_mode, 0);
        wr(8'h27);
        check("R3 R6 R8 command", cmd_vec(), 6'b001100);
        check("R2 mode held", {stop_sel, par_even, par_en, char_len, clk_fac}, 8'h7A);
        wr(8'h0C);
        check("R8 brk rx", cmd_vec(), 6'b110110);
        wr(8'h80);
        check("R8 hunt", cmd_vec(), 6'b110001);
    endtask

    task automatic t_errclr();
        wr(8'h10);
        check("R7 pulse high", err_clr, 1);
        @(negedge clk);
        check("R7 pulse one cycle", err_clr, 0);
    endtask

    task automatic t_irst();
        wr(8'h27);
        wr(8'h40);
        check("R5 cmd idle", cmd_vec(), 6'b110000);
        check("R5 no err_clr", err_clr, 0);
        check("R5 mode kept", {stop_sel, par_even, par_en, char_len, clk_fac}, 8'h7A);
        wr(8'h01);
        check("R5 next is mode", {stop_sel, par_even, par_en, char_len, clk_fac}, 8'h01);
        check("R5 cmd untouched", cmd_vec(), 6'b110000);
        wr(8'h01);
        check("R3 then command", tx_en, 1);
    endtask

    task automatic t_sync_two();
        hw_reset();
        wr(8'h0C);
        check("R4 sync_mode", sync_mode, 1);
        wr(8'hAA);
        check("R4 first sync", sync_chars, 16'h00AA);
        check("R4 no cmd on sync", cmd_vec(), 6'b110000);
        wr(8'h55);
        check("R4 second sync", sync_chars, 16'h55AA);
        check("R4 no cmd on sync2", cmd_vec(), 6'b110000);
        wr(8'h21);
        check("R4 then command", cmd_vec(), 6'b011000);
        check("R4 sync kept", sync_chars, 16'h55AA);
    endtask

    task automatic t_sync_one();
        wr(8'h40);
        wr(8'h80);
        check("R4 one-sync mode", {stop_sel, clk_fac}, 4'b1000);
        wr(8'h16);
        check("R4 single sync", sync_chars, 16'h5516);
        wr(8'h01);
        check("R4 command after one", tx_en, 1);
        check("R4 sync1 untouched", sync_chars, 16'h5516);
    endtask

    task automatic recover_and_probe(input string tag);
        wr(8'h00); wr(8'h00); wr(8'h00); wr(8'h40);
        wr(8'h4E);
        check({"R9 mode after recovery ", tag},
              {stop_sel, par_even, par_en, char_len, clk_fac}, 8'h4E);
        wr(8'h02);
        check({"R9 cmd after recovery ", tag}, dtr_n, 0);
    endtask

    task automatic t_recover();
        hw_reset();
        recover_and_probe("from mode");
        hw_reset(); wr(8'h00);
        recover_and_probe("from sync0");
        hw_reset(); wr(8'h00); wr(8'h11);
        recover_and_probe("from sync1");
        recover_and_probe("from cmd");
    endtask

    task automatic t_collide();
        wr(8'h23);
        wr(8'h72);
        check("R5 collide modem idle", {rts_n, dtr_n, tx_en}, 3'b110);
        check("R5 R7 collide no pulse", err_clr, 0);
        wr(8'h4D);
        check("R5 collide next mode", {char_len, clk_fac}, 4'b1101);
    endtask

    initial begin
        t_reset();
        t_async();
        t_errclr();
        t_irst();
        t_sync_two();
        t_sync_one();
        t_recover();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule